// File: doc/BRIEF.md
# Transceiver operating mode controller

This block is the mode state machine of a single-wire bus transceiver. It takes a digital supply-good indication, the enable pin, the transmit data level and a wake-request pulse that an upstream wake filter has already qualified. From these it derives the current operating mode and three enables: one for the external regulator inhibit switch, one for the transmit and receive path, and one for the bus termination.

Power-up and every wake event lead first to an intermediate fail-safe mode. The host then confirms normal operation by holding enable high. Normal operation is left for sleep only on a falling enable edge that occurs while the transmit input is high. Both enable-driven transitions pass through a tick-counted filter, so short enable pulses are rejected. Loss of supply returns the block to the unpowered mode from any mode.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the mode output reads the unpowered code. Mode codes are 2'b00 unpowered, 2'b01 fail-safe, 2'b10 normal and 2'b11 sleep.
- R2: In unpowered with supply_ok high at a clock edge, the mode becomes fail-safe at that edge.
- R3: In fail-safe, the mode becomes normal at the edge where en_pin has been sampled high on NORM_TICKS+1 consecutive edges. It is still fail-safe after NORM_TICKS such edges.
- R4: In normal, if en_pin is sampled low with txd_lvl high at the first low edge, the mode becomes sleep at the edge where en_pin has been low on SLEEP_TICKS+1 consecutive edges.
- R5: If txd_lvl is low at the first edge that samples en_pin low, the block stays in normal for as long as en_pin stays low, whatever txd_lvl does afterwards.
- R6: Every change of the sampled en_pin level restarts the filter count. A pulse shorter than the relevant window causes no mode change.
- R7: In sleep, wake_req high at an edge moves the mode to fail-safe at that edge. wake_req has no effect in fail-safe or normal.
- R8: supply_ok low at an edge forces unpowered at that edge, from any mode and before any other transition.
- R9: inh_en and term_en are high exactly in fail-safe and normal. comm_en is high only in normal. All three are low in unpowered and sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply is above its undervoltage threshold |
| en_pin | input | 1 | Enable pin level; reads low when disconnected |
| txd_lvl | input | 1 | Transmit data input level |
| wake_req | input | 1 | Qualified wake request, local or remote |
| mode | output | 2 | Current mode code (see R1) |
| inh_en | output | 1 | Regulator inhibit switch on |
| comm_en | output | 1 | Transmit and receive path enabled |
| term_en | output | 1 | Bus termination enabled |

## Verification
Two functions can fall in the same cycle. A supply loss can coincide with a completing enable filter, and a wake request can arrive on the very edge that would complete sleep entry. The random phase drops supply_ok and pulses wake_req at arbitrary points while enable toggles, so these coincidences occur. A bench reference model, built from the requirements, judges every edge, and it always lets the supply-loss transition win.

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl #(
  parameter int NORM_TICKS  = 7,
  parameter int SLEEP_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       en_pin,
  input  logic       txd_lvl,
  input  logic       wake_req,
  output logic [1:0] mode,
  output logic       inh_en,
  output logic       comm_en,
  output logic       term_en
);
  localparam int MAXT = (NORM_TICKS > SLEEP_TICKS) ? NORM_TICKS : SLEEP_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [1:0] M_OFF = 2'b00, M_SAFE = 2'b01, M_RUN = 2'b10, M_SLP = 2'b11;

  logic          en_q, sleep_arm, en_edge, norm_ok, sleep_ok;
  logic [CW-1:0] run_cnt;
  logic [1:0]    mode_nx;

  assign en_edge  = en_pin ^ en_q;
  assign norm_ok  = en_pin && !en_edge && (run_cnt >= CW'(NORM_TICKS));
  assign sleep_ok = !en_pin && !en_edge && sleep_arm && (run_cnt >= CW'(SLEEP_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      run_cnt   <= '0;
      sleep_arm <= 1'b0;
    end else begin
      en_q <= en_pin;
      if (en_edge) begin
        run_cnt   <= CW'(1);
        sleep_arm <= !en_pin && txd_lvl;
      end else if (run_cnt != CW'(MAXT)) begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    mode_nx = mode;
    if (!supply_ok) mode_nx = M_OFF;
    else begin
      case (mode)
        M_OFF:   mode_nx = M_SAFE;
        M_SAFE:  if (norm_ok)  mode_nx = M_RUN;
        M_RUN:   if (sleep_ok) mode_nx = M_SLP;
        default: if (wake_req) mode_nx = M_SAFE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= M_OFF;
    else        mode <= mode_nx;
  end

  assign inh_en  = (mode == M_SAFE) || (mode == M_RUN);
  assign term_en = inh_en;
  assign comm_en = (mode == M_RUN);
endmodule

module xcvr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       en_pin,
  input logic       txd_lvl,
  input logic       wake_req,
  input logic [1:0] mode,
  input logic       inh_en,
  input logic       comm_en,
  input logic       term_en
);
  AST_LEAVE_OFF_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && $past(mode) == 2'b00) |-> $past(supply_ok)); // R2
  AST_RUN_ONLY_FROM_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && $past(mode) != 2'b10) |-> ($past(mode) == 2'b01 && $past(en_pin))); // R3
  AST_SLEEP_ONLY_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && $past(mode) != 2'b11) |-> ($past(mode) == 2'b10 && !$past(en_pin))); // R4
  AST_WAKE_TO_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && mode == 2'b11 && wake_req) |=> (mode == 2'b01)); // R7
  AST_SUPPLY_LOSS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (mode == 2'b00)); // R8
  AST_COMM_NEEDS_INH: assert property (@(posedge clk) disable iff (!rst_n)
    comm_en |-> (inh_en && term_en)); // R9
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk chk_i (.*);

// File: tb/xcvr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_tb_top;
  localparam int NT = 7;
  localparam int ST = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 1'b0, en_pin = 1'b0, txd_lvl = 1'b0, wake_req = 1'b0;
  logic [1:0] mode;
  logic inh_en, comm_en, term_en;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  int m_mode, m_run;
  bit m_prev_en, m_ftxd;

  always #5 clk = ~clk;

  xcvr_mode_ctrl #(.NORM_TICKS(NT), .SLEEP_TICKS(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .en_pin(en_pin),
    .txd_lvl(txd_lvl), .wake_req(wake_req), .mode(mode),
    .inh_en(inh_en), .comm_en(comm_en), .term_en(term_en));

  function automatic logic [2:0] exp_outs(int md);
    case (md)
      1, 2:    exp_outs = {1'b1, md == 2, 1'b1};
      default: exp_outs = 3'b000;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (en_pin != m_prev_en) begin
      m_run = 1;
      if (!en_pin) m_ftxd = txd_lvl;
    end else if (m_run < 1000) m_run++;
    m_prev_en = en_pin;
    if (!supply_ok) m_mode = 0;
    else case (m_mode)
      0: m_mode = 1;
      1: if (en_pin && m_run >= NT + 1) m_mode = 2;
      2: if (!en_pin && m_ftxd && m_run >= ST + 1) m_mode = 3;
      default: if (wake_req) m_mode = 1;
    endcase
  endtask

  task automatic tick(bit s, bit e, bit t, bit w);
    supply_ok = s; en_pin = e; txd_lvl = t; wake_req = w;
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_outs(string tag, int md);
    check({tag, " mode"}, int'(mode), md);
    check({tag, " outs"}, int'({inh_en, comm_en, term_en}), int'(exp_outs(md)));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_mode = 0; m_run = 0; m_prev_en = 0; m_ftxd = 0;
    repeat (3) @(negedge clk);
    check_outs("R1 in reset", 0);
    rst_n = 1'b1;
    tick(0, 0, 1, 0);
    check_outs("R1 after reset", 0);
    tick(1, 0, 1, 0);
    check_outs("R2 power-up", 1);
    check_outs("R9 fail-safe", 1);

    for (int i = 0; i < NT; i++) tick(1, 1, 1, 0);
    tick(1, 0, 1, 0);
    check_outs("R6 short pulse", 1);
    for (int i = 0; i < 5; i++) tick(1, 1, 1, 0);
    tick(1, 0, 1, 0);
    for (int i = 0; i < NT; i++) tick(1, 1, 1, 0);
    check_outs("R6 restart", 1);
    tick(1, 1, 1, 1);
    check_outs("R3 window end", 2);
    check_outs("R9 normal", 2);
    tick(1, 1, 1, 1);
    check_outs("R7 wake in normal", 2);

    tick(1, 0, 0, 0);
    tick(1, 0, 1, 0);
    for (int i = 0; i < ST + 4; i++) tick(1, 0, 1, 0);
    check_outs("R5 txd low at fall", 2);
    tick(1, 1, 1, 0);

    for (int i = 0; i < ST; i++) tick(1, 0, 1, 0);
    check_outs("R4 before window", 2);
    tick(1, 0, 0, 0);
    check_outs("R4 sleep", 3);
    check_outs("R9 sleep", 3);
    tick(1, 1, 0, 1);
    check_outs("R7 wake", 1);
    tick(1, 1, 0, 1);
    check_outs("R7 wake in fail-safe", 1);
    for (int i = 0; i < NT + 1; i++) tick(1, 1, 1, 0);
    check_outs("R3 from wake", 2);
    tick(0, 1, 1, 0);
    check_outs("R8 supply loss", 0);
    check(  "R8 model", m_mode, 0);

    for (int i = 0; i < 6000; i++) begin
      bit s, e, t, w;
      s = ($urandom_range(0, 199) != 0);
      e = ($urandom_range(0, 5) == 0) ? !en_pin : en_pin;
      t = $urandom_range(0, 1);
      w = ($urandom_range(0, 19) == 0);
      tick(s, e, t, w);
      check_outs("MODEL", m_mode);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));
endmodule